// File: doc/BRIEF.md
# Row/Column Broadcast Context Store

This block holds the configuration words for an 8x8 array of processing cells. Storage is divided into two halves. One half is used when lines are rows and the other when lines are columns. Each half keeps one context set per line, and each set holds 16 words of 32 bits. A broadcast request names a line orientation and a word index. One cycle later the store places the indexed word of every set onto a 256-bit context bus, one 32-bit slice per line. Every cell on a line therefore receives the same word.

An 8-bit line-enable mask is registered alongside the bus. When the single-line option is off, the mask enables every line. When it is on, the mask enables only the chosen line. This is used, for example, to load the array one column at a time with a single context plane.

An independent write port loads words into either half while broadcasts go on without a stall. New configurations can therefore be staged at no cost in cycles.

Top module: `ctx_bcast_store`

## Requirements
- R1: After synchronous reset, `bus_valid` is 0, `line_en` is 8'h00 and `ctx_bus` is all zeros.
- R2: A write with `wr_en`=1 stores `wr_data` at the entry addressed by `wr_addr`. Bit 7 selects the half (0 = row half, 1 = column half), bits 6:4 select the set (line) and bits 3:0 select the word.
- R3: When `bc_valid`=1 with `bc_mode`=0 (rows), slice i of `ctx_bus` (bits 32*i+31 down to 32*i) carries word `bc_index` of set i in the row half.
- R4: When `bc_valid`=1 with `bc_mode`=1 (columns), slice i of `ctx_bus` carries word `bc_index` of set i in the column half.
- R5: A broadcast request appears at the outputs exactly one clock later. In that cycle `bus_valid` is 1 and `bus_mode` equals the requested `bc_mode`. In a cycle that follows a clock with `bc_valid`=0, `bus_valid` is 0.
- R6: In a cycle that follows a clock with no broadcast request, `ctx_bus` keeps its previous value and `line_en` is 8'h00. This holds even if a write hits the entries last read.
- R7: When a broadcast is issued with `sel_en`=0, `line_en` is 8'hFF.
- R8: When a broadcast is issued with `sel_en`=1, `line_en` has exactly bit `sel_line` set.
- R9: A write may occur in the same cycle as a broadcast without disturbing it. If the write targets an entry being read in that cycle, the bus shows the old word, and the next broadcast of that entry shows the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bc_valid | input | 1 | Broadcast request this cycle |
| bc_mode | input | 1 | 0 = row broadcast, 1 = column broadcast |
| bc_index | input | 4 | Word index inside every set |
| sel_en | input | 1 | Enable only one line |
| sel_line | input | 3 | Line enabled when `sel_en` is 1 |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | {half, set, word} write address |
| wr_data | input | 32 | Word to store |
| ctx_bus | output | 256 | Eight 32-bit context words, slice i for line i |
| line_en | output | 8 | Registered line-enable mask |
| bus_valid | output | 1 | `ctx_bus` and `line_en` carry a new broadcast |
| bus_mode | output | 1 | Orientation of the broadcast on the bus |

## Verification
A corrupted entry, a swapped set decode or a wrong half selection shows up as a wrong slice on `ctx_bus` one cycle after the broadcast that reads it. A full sweep over both halves, all sixteen indices and every mask setting exposes any such error within a few hundred cycles. A write path that leaks into the read port, or a lost read-before-write order, shows as an early new word in the collision cycle or as a changed bus during idle cycles. A stale valid or mode register appears as a mismatch on `bus_valid` or `bus_mode` in the very next cycle.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
    parameter int NLINES  = 8;
    parameter int NWORDS  = 16;
    parameter int WORD_W  = 32;
    localparam int LINE_W = $clog2(NLINES);
    localparam int IDX_W  = $clog2(NWORDS);
    localparam int ADDR_W = 1 + LINE_W + IDX_W;
    localparam int BUS_W  = NLINES * WORD_W;

    typedef enum logic {MODE_ROW = 1'b0, MODE_COL = 1'b1} bc_mode_e;

    typedef struct packed {
        logic               valid;
        bc_mode_e           mode;
        logic [IDX_W-1:0]   index;
        logic               single;
        logic [LINE_W-1:0]  line;
    } bc_req_t;

    typedef struct packed {
        logic               en;
        bc_mode_e           half;
        logic [LINE_W-1:0]  set;
        logic [IDX_W-1:0]   word;
        logic [WORD_W-1:0]  data;
    } wr_req_t;

    function automatic logic [NLINES-1:0] line_mask(input logic single,
                                                   input logic [LINE_W-1:0] line);
        logic [NLINES-1:0] m;
        if (single) begin
            m = '0;
            m[line] = 1'b1;
        end else begin
            m = '1;
        end
        return m;
    endfunction
endpackage

// File: rtl/ctx_bank.sv
module ctx_bank
    import ctx_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [LINE_W-1:0]              wr_set,
    input  logic [IDX_W-1:0]               wr_word,
    input  logic [WORD_W-1:0]              wr_data,
    input  logic                           rd_en,
    input  logic [IDX_W-1:0]               rd_word,
    output logic [NLINES-1:0][WORD_W-1:0]  rd_q
);
    for (genvar s = 0; s < NLINES; s++) begin : g_set
        logic [WORD_W-1:0] store [NWORDS];
        logic              hit;

        assign hit = wr_en && (wr_set == LINE_W'(s));

        always_ff @(posedge clk) begin
            if (hit) begin
                store[wr_word] <= wr_data;
            end
        end

        // Read uses the value before this edge's write: old data on collision.
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_q[s] <= '0;
            end else if (rd_en) begin
                rd_q[s] <= store[rd_word];
            end
        end
    end
endmodule

// File: rtl/ctx_issue_ctl.sv
module ctx_issue_ctl
    import ctx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bc_req_t            req,
    output logic               valid_q,
    output bc_mode_e           mode_q,
    output logic [NLINES-1:0]  mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            mode_q  <= MODE_ROW;
            mask_q  <= '0;
        end else begin
            valid_q <= req.valid;
            if (req.valid) begin
                mode_q <= req.mode;
                mask_q <= line_mask(req.single, req.line);
            end else begin
                mask_q <= '0;
            end
        end
    end
endmodule

// File: rtl/ctx_bcast_store.sv
module ctx_bcast_store
    import ctx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bc_valid,
    input  logic                  bc_mode,
    input  logic [IDX_W-1:0]      bc_index,
    input  logic                  sel_en,
    input  logic [LINE_W-1:0]     sel_line,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [WORD_W-1:0]     wr_data,
    output logic [BUS_W-1:0]      ctx_bus,
    output logic [NLINES-1:0]     line_en,
    output logic                  bus_valid,
    output logic                  bus_mode
);
    bc_req_t  req;
    wr_req_t  wr;
    bc_mode_e mode_q;
    logic [NLINES-1:0][WORD_W-1:0] half_q [2];

    always_comb begin
        req.valid  = bc_valid;
        req.mode   = bc_mode_e'(bc_mode);
        req.index  = bc_index;
        req.single = sel_en;
        req.line   = sel_line;
        wr.en      = wr_en;
        wr.half    = bc_mode_e'(wr_addr[ADDR_W-1]);
        wr.set     = wr_addr[IDX_W +: LINE_W];
        wr.word    = wr_addr[IDX_W-1:0];
        wr.data    = wr_data;
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        ctx_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr.en && (wr.half == bc_mode_e'(h))),
            .wr_set  (wr.set),
            .wr_word (wr.word),
            .wr_data (wr.data),
            .rd_en   (req.valid && (req.mode == bc_mode_e'(h))),
            .rd_word (req.index),
            .rd_q    (half_q[h])
        );
    end

    ctx_issue_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .valid_q (bus_valid),
        .mode_q  (mode_q),
        .mask_q  (line_en)
    );

    assign ctx_bus  = (mode_q == MODE_COL) ? half_q[1] : half_q[0];
    assign bus_mode = (mode_q == MODE_COL);
endmodule

// File: rtl/ctx_bcast_store_chk.sv
module ctx_bcast_store_chk
    import ctx_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  bc_valid,
    input logic                  bc_mode,
    input logic                  sel_en,
    input logic [LINE_W-1:0]     sel_line,
    input logic [BUS_W-1:0]      ctx_bus,
    input logic [NLINES-1:0]     line_en,
    input logic                  bus_valid,
    input logic                  bus_mode
);
    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
        bc_valid |=> bus_valid);

    assert_valid_drops_R5: assert property (@(posedge clk) disable iff (rst)
        !bc_valid |=> !bus_valid);

    assert_mode_follows_R5: assert property (@(posedge clk) disable iff (rst)
        bc_valid |=> (bus_mode == $past(bc_mode)));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !bc_valid |=> ($stable(ctx_bus) && line_en == '0));

    assert_full_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && !sel_en) |=> (line_en == '1));

    assert_single_line_R8: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && sel_en) |=> ($onehot(line_en) && line_en[$past(sel_line)]));
endmodule

bind ctx_bcast_store ctx_bcast_store_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bc_valid  (bc_valid),
    .bc_mode   (bc_mode),
    .sel_en    (sel_en),
    .sel_line  (sel_line),
    .ctx_bus   (ctx_bus),
    .line_en   (line_en),
    .bus_valid (bus_valid),
    .bus_mode  (bus_mode)
);

// File: tb/sim_ctx_bcast_store.sv
module sim_ctx_bcast_store;
    logic         clk = 1'b0;
    logic         rst;
    logic         bc_valid, bc_mode, sel_en, wr_en;
    logic [3:0]   bc_index;
    logic [2:0]   sel_line;
    logic [7:0]   wr_addr;
    logic [31:0]  wr_data;
    logic [255:0] ctx_bus;
    logic [7:0]   line_en;
    logic         bus_valid, bus_mode;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0]  model [256];
    logic [255:0] prev_bus;
    bit           done = 0;

    always #4 clk = ~clk;

    ctx_bcast_store u0 (
        .clk(clk), .rst(rst), .bc_valid(bc_valid), .bc_mode(bc_mode),
        .bc_index(bc_index), .sel_en(sel_en), .sel_line(sel_line),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctx_bus(ctx_bus), .line_en(line_en), .bus_valid(bus_valid),
        .bus_mode(bus_mode)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int a);
        return 32'h5A3C_0000 ^ (a * 32'h0001_0203) ^ (a << 20);
    endfunction

    // Apply one cycle of stimulus, then check the registered outputs.
    task automatic step(input logic v, input logic m, input logic [3:0] idx,
                        input logic se, input logic [2:0] ln,
                        input logic we, input logic [7:0] wa, input logic [31:0] wd,
                        input string tag_bus);
        logic [255:0] eb;
        logic [7:0]   em;
        eb = prev_bus;
        em = 8'h00;
        if (v) begin
            for (int i = 0; i < 8; i++)
                eb[32*i +: 32] = model[int'(m)*128 + i*16 + int'(idx)];
            em = se ? (8'h01 << ln) : 8'hFF;
        end
        bc_valid = v; bc_mode = m; bc_index = idx; sel_en = se; sel_line = ln;
        wr_en = we; wr_addr = wa; wr_data = wd;
        @(negedge clk);
        chk(ctx_bus === eb, tag_bus, ctx_bus, eb);
        chk(bus_valid === v, "R5 bus_valid", 256'(bus_valid), 256'(v));
        if (v) chk(bus_mode === m, "R5 bus_mode", 256'(bus_mode), 256'(m));
        chk(line_en === em, !v ? "R6 line_en idle" : (se ? "R8 one-hot mask" : "R7 full mask"),
            256'(line_en), 256'(em));
        if (we) model[wa] = wd;
        prev_bus = eb;
    endtask

    initial begin
        bc_valid = 0; bc_mode = 0; bc_index = 0; sel_en = 0; sel_line = 0;
        wr_en = 0; wr_addr = 0; wr_data = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(bus_valid === 1'b0, "R1 bus_valid", 256'(bus_valid), 0);
        chk(line_en === 8'h00, "R1 line_en", 256'(line_en), 0);
        chk(ctx_bus === '0, "R1 ctx_bus", ctx_bus, 0);
        rst = 0;
        prev_bus = '0;
        // R2: fill every entry through the {half,set,word} address
        for (int a = 0; a < 256; a++)
            step(0, 0, 0, 0, 0, 1, 8'(a), pat(a), "R6 idle bus during fill");
        // R3/R4/R7/R8: sweep halves, indices and mask settings
        for (int m = 0; m < 2; m++)
            for (int idx = 0; idx < 16; idx++)
                for (int se = 0; se < 2; se++)
                    for (int ln = 0; ln < 8; ln++)
                        step(1, 1'(m), 4'(idx), 1'(se), 3'(ln), 0, 0, 0,
                             m == 0 ? "R3 row broadcast R2" : "R4 column broadcast R2");
        // R9: writes into the other half during back-to-back broadcasts
        for (int idx = 0; idx < 16; idx++)
            step(1, 0, 4'(idx), 0, 0, 1, {1'b1, 3'(idx % 8), 4'(idx)},
                 32'hC0DE_0000 | idx, "R9 broadcast with concurrent write");
        for (int idx = 0; idx < 16; idx++)
            step(1, 1, 4'(idx), 0, 0, 0, 0, 0, "R9 column half after writes");
        // R9: collision returns old word, next read returns new
        step(1, 0, 4'd5, 0, 0, 1, {1'b0, 3'd2, 4'd5}, 32'hDEAD_BEEF, "R9 same-entry old data");
        step(1, 0, 4'd5, 0, 0, 0, 0, 0, "R9 new data visible");
        chk(ctx_bus[64 +: 32] === 32'hDEAD_BEEF, "R9 slice 2 new word",
            256'(ctx_bus[64 +: 32]), 256'(32'hDEAD_BEEF));
        // R6: idle cycles hold the bus even when its entries are rewritten
        step(0, 1, 4'd9, 1, 3'd3, 1, {1'b0, 3'd0, 4'd5}, 32'h1111_2222, "R6 hold under write");
        step(0, 0, 4'd5, 0, 0, 0, 0, 0, "R6 hold idle");
        step(1, 0, 4'd5, 1, 3'd7, 0, 0, 0, "R3 row after idle");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule